// File: doc/BRIEF.md
# Mode-Banked Register File

A 32-bit register file for a processor core with several operating modes. Software always sees sixteen general registers, addressed by a 4-bit logical index. Behind them sit 31 physical registers. The current mode decides which physical register each index reaches. Low indices are common to every mode. The stack and link indices get a private copy in each exception mode. The fast-interrupt mode also has its own copies of indices 8 to 12, so its handler can run without saving them.

The block offers:
- two combinational read ports and one write port, which takes effect at the clock edge;
- a current status register that is visible in every mode;
- a saved status register for each exception mode;
- a program-counter path that either steps by one word or takes a value from the write port.

The mode is held in a register inside the block. An external sequencer loads it through a strobe, so any write in the same cycle is steered by the mode that was in force before the change.

Top module: `banked_regfile`

## Requirements
- R1: Logical indices 0 to 7 reach the same physical register in every mode, so a value written in one mode reads back unchanged in any other mode. Mode codes are: user 0, fast interrupt 1, interrupt 2, supervisor 3, abort 4, undefined 5, system 6. Code 7 is banked like user.
- R2: Indices 8 to 12 are shared by all modes except fast interrupt, which owns a separate copy of each.
- R3: Indices 13 (stack) and 14 (link) have one copy shared by user and system mode. Each of modes 1 to 5 has its own private pair.
- R4: `pc_o` gives the stored program counter. A read of index 15 on either read port returns the stored value plus 8.
- R5: When `pc_inc_i` is high and index 15 is not being written, the program counter grows by 4 at the clock edge.
- R6: A write to index 15 through the write port loads `wd_i` into the program counter and takes priority over `pc_inc_i` in the same cycle.
- R7: The current status register is written from `cpsr_wd_i` when `cpsr_we_i` is high, in any mode, and is read on `cpsr_o`.
- R8: Modes 1 to 5 each own a saved status register, which is written through `spsr_we_i` and read on `spsr_o`. In modes 0, 6 and 7 `spsr_o` reads zero and a saved status write changes nothing.
- R9: After reset every general and status register is zero and the mode is supervisor (3). Index 15 therefore reads 8.
- R10: When `mode_we_i` is high, `mode_i` becomes the mode at the next edge. Register and saved status writes in that same cycle use the previous mode.
- R11: The two read ports decode their indices independently and combinationally, so they can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_we_i | input | 1 | Load a new mode |
| mode_i | input | 3 | New mode code |
| mode_o | output | 3 | Current mode |
| ra_addr_i | input | 4 | Read port A logical index |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 4 | Read port B logical index |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 4 | Write logical index |
| wd_i | input | 32 | Write data |
| pc_inc_i | input | 1 | Advance program counter by 4 |
| pc_o | output | 32 | Stored program counter |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wd_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status |
| spsr_we_i | input | 1 | Saved status write enable |
| spsr_wd_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status of current mode |

## Verification
The program-counter step and a write-port store to index 15 can land on the same edge. A mode change can also coincide with a register write that must still go to the old bank. Random stimulus raises the write, step and mode strobes independently, so all of these pairings occur many times. Directed cycles force both collisions explicitly. After each edge the bench compares `pc_o` and the banked reads with a bench model that applies the override priority and the old-mode steering.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int XLEN     = 32;
  localparam int NUM_LOG  = 16;
  localparam int NUM_GPR  = 31;
  localparam int NUM_SPSR = 5;
  localparam int LIDX_W   = $clog2(NUM_LOG);
  localparam int GIDX_W   = $clog2(NUM_GPR);
  localparam int SIDX_W   = $clog2(NUM_SPSR);
  localparam int PC_IDX   = 15;
  localparam int LR_IDX   = 14;
  localparam int SP_IDX   = 13;
  localparam int FIQ_LO   = 8;
  localparam int FIQ_BASE = 16;
  localparam int EXC_BASE = FIQ_BASE + (LR_IDX - FIQ_LO + 1);
  localparam int PC_STEP  = 4;
  localparam int PC_LEAD  = 8;

  typedef enum logic [2:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5,
    MODE_SYS = 3'd6,
    MODE_BAD = 3'd7
  } cpu_mode_e;
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import rf_pkg::*;
(
  input  cpu_mode_e         mode_i,
  input  logic [LIDX_W-1:0] lidx_i,
  output logic [GIDX_W-1:0] pidx_o
);
  logic in_fiq_range;
  logic is_sp_lr;
  logic [GIDX_W-1:0] exc_base;

  assign in_fiq_range = (lidx_i >= LIDX_W'(FIQ_LO)) && (lidx_i <= LIDX_W'(LR_IDX));
  assign is_sp_lr     = (lidx_i == LIDX_W'(SP_IDX)) || (lidx_i == LIDX_W'(LR_IDX));

  // each exception mode owns a consecutive SP/LR pair
  always_comb begin
    unique case (mode_i)
      MODE_IRQ: exc_base = GIDX_W'(EXC_BASE);
      MODE_SVC: exc_base = GIDX_W'(EXC_BASE + 2);
      MODE_ABT: exc_base = GIDX_W'(EXC_BASE + 4);
      MODE_UND: exc_base = GIDX_W'(EXC_BASE + 6);
      default:  exc_base = '0;
    endcase
  end

  always_comb begin
    pidx_o = GIDX_W'(lidx_i);
    if (mode_i == MODE_FIQ && in_fiq_range)
      pidx_o = GIDX_W'(FIQ_BASE) + GIDX_W'(lidx_i - LIDX_W'(FIQ_LO));
    else if (is_sp_lr && exc_base != '0)
      pidx_o = exc_base + GIDX_W'(lidx_i == LIDX_W'(LR_IDX));
  end
endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array
  import rf_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [GIDX_W-1:0]     widx_i,
  input  logic [XLEN-1:0]       wd_i,
  input  logic                  pc_inc_i,
  input  logic [GIDX_W-1:0]     ridx_i [NRD],
  output logic [XLEN-1:0]       rdata_o [NRD],
  output logic [XLEN-1:0]       pc_o
);
  logic [XLEN-1:0] regs [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    if (g == PC_IDX) begin : g_pc
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     regs[g] <= '0;
        else if (we_i && widx_i == GIDX_W'(g))           regs[g] <= wd_i;
        else if (pc_inc_i)                               regs[g] <= regs[g] + XLEN'(PC_STEP);
      end
    end else begin : g_gp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     regs[g] <= '0;
        else if (we_i && widx_i == GIDX_W'(g))           regs[g] <= wd_i;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (ridx_i[p] < GIDX_W'(NUM_GPR)) ? regs[ridx_i[p]] : '0;
  end

  assign pc_o = regs[PC_IDX];

  AST_PC_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx_i == GIDX_W'(PC_IDX)) |=> (pc_o == $past(wd_i))); // R6
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_inc_i && !(we_i && widx_i == GIDX_W'(PC_IDX))) |=> (pc_o == $past(pc_o) + XLEN'(PC_STEP))); // R5
endmodule

// File: rtl/rf_psr_bank.sv
module rf_psr_bank
  import rf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cpu_mode_e       mode_i,
  input  logic            cpsr_we_i,
  input  logic [XLEN-1:0] cpsr_wd_i,
  input  logic            spsr_we_i,
  input  logic [XLEN-1:0] spsr_wd_i,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] spsr_o
);
  logic [XLEN-1:0]   cpsr_q;
  logic [XLEN-1:0]   spsr_q [NUM_SPSR];
  logic              has_spsr;
  logic [SIDX_W-1:0] sidx;

  always_comb begin
    has_spsr = 1'b1;
    sidx     = '0;
    unique case (mode_i)
      MODE_FIQ: sidx = SIDX_W'(0);
      MODE_IRQ: sidx = SIDX_W'(1);
      MODE_SVC: sidx = SIDX_W'(2);
      MODE_ABT: sidx = SIDX_W'(3);
      MODE_UND: sidx = SIDX_W'(4);
      default:  has_spsr = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cpsr_q <= '0;
    else if (cpsr_we_i) cpsr_q <= cpsr_wd_i;
  end

  for (genvar s = 0; s < NUM_SPSR; s++) begin : g_spsr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          spsr_q[s] <= '0;
      else if (spsr_we_i && has_spsr && sidx == SIDX_W'(s)) spsr_q[s] <= spsr_wd_i;
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = has_spsr ? spsr_q[sidx] : '0;

  AST_CPSR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_we_i |=> (cpsr_o == $past(cpsr_wd_i))); // R7
  AST_SPSR_USER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_USR || mode_i == MODE_SYS || mode_i == MODE_BAD) |-> (spsr_o == '0)); // R8
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [2:0]        mode_i,
  output logic [2:0]        mode_o,
  input  logic [LIDX_W-1:0] ra_addr_i,
  output logic [XLEN-1:0]   ra_data_o,
  input  logic [LIDX_W-1:0] rb_addr_i,
  output logic [XLEN-1:0]   rb_data_o,
  input  logic              we_i,
  input  logic [LIDX_W-1:0] wa_addr_i,
  input  logic [XLEN-1:0]   wd_i,
  input  logic              pc_inc_i,
  output logic [XLEN-1:0]   pc_o,
  input  logic              cpsr_we_i,
  input  logic [XLEN-1:0]   cpsr_wd_i,
  output logic [XLEN-1:0]   cpsr_o,
  input  logic              spsr_we_i,
  input  logic [XLEN-1:0]   spsr_wd_i,
  output logic [XLEN-1:0]   spsr_o
);
  localparam int NRD = 2;
  localparam int NMAP = NRD + 1;

  cpu_mode_e         mode_q;
  logic [LIDX_W-1:0] lidx [NMAP];
  logic [GIDX_W-1:0] pidx [NMAP];
  logic [GIDX_W-1:0] ridx [NRD];
  logic [XLEN-1:0]   rraw [NRD];
  logic [XLEN-1:0]   rout [NRD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_SVC;
    else if (mode_we_i) mode_q <= cpu_mode_e'(mode_i);
  end
  assign mode_o = mode_q;

  assign lidx[0] = ra_addr_i;
  assign lidx[1] = rb_addr_i;
  assign lidx[2] = wa_addr_i;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rf_bank_map u_map (.mode_i(mode_q), .lidx_i(lidx[m]), .pidx_o(pidx[m]));
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    assign ridx[p] = pidx[p];
    // index 15 shows the fetch lead
    assign rout[p] = (lidx[p] == LIDX_W'(PC_IDX)) ? rraw[p] + XLEN'(PC_LEAD) : rraw[p];
  end

  rf_gpr_array #(.NRD(NRD)) u_gpr (
    .clk_i, .rst_ni,
    .we_i, .widx_i(pidx[2]), .wd_i,
    .pc_inc_i,
    .ridx_i(ridx), .rdata_o(rraw),
    .pc_o
  );

  rf_psr_bank u_psr (
    .clk_i, .rst_ni, .mode_i(mode_q),
    .cpsr_we_i, .cpsr_wd_i, .spsr_we_i, .spsr_wd_i,
    .cpsr_o, .spsr_o
  );

  assign ra_data_o = rout[0];
  assign rb_data_o = rout[1];

  AST_PC_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == LIDX_W'(PC_IDX)) |-> (ra_data_o == pc_o + XLEN'(PC_LEAD))); // R4
  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_o == $past(mode_i))); // R10
  AST_SAME_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == rb_addr_i) |-> (ra_data_o == rb_data_o)); // R11
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 0;
  logic [2:0]  mode_i = 0;
  logic [2:0]  mode_o;
  logic [3:0]  ra_addr_i = 0, rb_addr_i = 0, wa_addr_i = 0;
  logic [31:0] ra_data_o, rb_data_o, wd_i = 0, pc_o;
  logic        we_i = 0, pc_inc_i = 0, cpsr_we_i = 0, spsr_we_i = 0;
  logic [31:0] cpsr_wd_i = 0, cpsr_o, spsr_wd_i = 0, spsr_o;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_gpr [31];
  logic [31:0] m_cpsr;
  logic [31:0] m_spsr [8];
  logic [2:0]  m_mode;
  logic        last_pcw;

  always #10 clk_i = ~clk_i;

  banked_regfile i_banked_regfile (.*);

  function automatic int ref_idx(logic [2:0] md, logic [3:0] a);
    if (md == 3'd1 && a >= 8 && a <= 14) return 16 + int'(a) - 8;
    if (a == 13 || a == 14) begin
      case (md)
        3'd2: return 23 + int'(a) - 13;
        3'd3: return 25 + int'(a) - 13;
        3'd4: return 27 + int'(a) - 13;
        3'd5: return 29 + int'(a) - 13;
        default: ;
      endcase
    end
    return int'(a);
  endfunction

  function automatic logic has_sp(logic [2:0] md);
    return md >= 3'd1 && md <= 3'd5;
  endfunction

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    if (a == 15) return m_gpr[15] + 32'd8;
    return m_gpr[ref_idx(m_mode, a)];
  endfunction

  function automatic string rd_tag(logic [3:0] a);
    if (a < 8) return "R1";
    if (a < 13) return "R2";
    if (a < 15) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(rd_tag(ra_addr_i), ra_data_o, exp_rd(ra_addr_i));
    chk(rd_tag(rb_addr_i), rb_data_o, exp_rd(rb_addr_i)); // R11 port B
    chk(last_pcw ? "R6" : "R5", pc_o, m_gpr[15]);
    chk("R7", cpsr_o, m_cpsr);
    chk("R8", spsr_o, has_sp(m_mode) ? m_spsr[m_mode] : 32'd0);
    chk("R10", {29'd0, mode_o}, {29'd0, m_mode});
  endtask

  task automatic model_edge();
    logic [31:0] npc;
    npc = m_gpr[15];
    if (pc_inc_i) npc = npc + 32'd4;
    if (we_i) m_gpr[ref_idx(m_mode, wa_addr_i)] = wd_i;
    if (!(we_i && wa_addr_i == 15)) m_gpr[15] = npc;
    last_pcw = we_i && wa_addr_i == 15;
    if (cpsr_we_i) m_cpsr = cpsr_wd_i;
    if (spsr_we_i && has_sp(m_mode)) m_spsr[m_mode] = spsr_wd_i;
    if (mode_we_i) m_mode = mode_i;
  endtask

  // inputs already driven after a negedge; check, then clock
  task automatic cycle();
    #2 check_all();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
  endtask

  task automatic idle();
    mode_we_i = 0; we_i = 0; pc_inc_i = 0; cpsr_we_i = 0; spsr_we_i = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    idle(); we_i = 1; wa_addr_i = a; wd_i = d; cycle();
  endtask

  task automatic setmode(logic [2:0] md);
    idle(); mode_we_i = 1; mode_i = md; cycle();
  endtask

  task automatic rd(logic [3:0] a, logic [3:0] b);
    idle(); ra_addr_i = a; rb_addr_i = b; cycle();
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 31; i++) m_gpr[i] = '0;
    for (int i = 0; i < 8; i++) m_spsr[i] = '0;
    m_cpsr = '0; m_mode = 3'd3; last_pcw = 0;
    #35;
    // R9 reset state
    for (int a = 0; a < 16; a++) begin
      ra_addr_i = 4'(a); #1;
      chk("R9", ra_data_o, (a == 15) ? 32'd8 : 32'd0);
    end
    chk("R9", {29'd0, mode_o}, 32'd3);
    chk("R9", pc_o | cpsr_o | spsr_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 shared low index, R2 fiq bank, R3 sp/lr banks
    wr(4'd3, 32'h0000_0033);
    wr(4'd9, 32'h0000_0099);
    wr(4'd13, 32'h5c5c_0013);
    setmode(3'd1);
    wr(4'd9, 32'hf1f1_0009);
    wr(4'd13, 32'hf1f1_0013);
    rd(4'd3, 4'd9);
    setmode(3'd0);
    rd(4'd9, 4'd13);
    wr(4'd14, 32'h0505_0014);
    setmode(3'd6);
    rd(4'd14, 4'd3);
    setmode(3'd3);
    rd(4'd13, 4'd14);

    // R6 write to index 15 together with increment
    idle(); we_i = 1; wa_addr_i = 4'd15; wd_i = 32'h0000_1000; pc_inc_i = 1; cycle();
    idle(); pc_inc_i = 1; cycle();
    rd(4'd15, 4'd15);

    // R8 saved status ignored in user mode, kept in supervisor
    idle(); spsr_we_i = 1; spsr_wd_i = 32'h0000_00d3; cycle();
    setmode(3'd0);
    idle(); spsr_we_i = 1; spsr_wd_i = 32'hdead_beef; cycle();
    setmode(3'd3);
    rd(4'd0, 4'd1);

    // R10 mode change and write in the same cycle use old bank
    idle(); mode_we_i = 1; mode_i = 3'd2; we_i = 1; wa_addr_i = 4'd13; wd_i = 32'h0bad_0013; cycle();
    rd(4'd13, 4'd12);
    setmode(3'd3);
    rd(4'd13, 4'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      mode_we_i = ($urandom % 5) == 0;
      mode_i    = 3'($urandom);
      we_i      = $urandom % 2;
      wa_addr_i = 4'($urandom);
      wd_i      = $urandom;
      pc_inc_i  = $urandom % 2;
      cpsr_we_i = ($urandom % 4) == 0;
      cpsr_wd_i = $urandom;
      spsr_we_i = ($urandom % 3) == 0;
      spsr_wd_i = $urandom;
      ra_addr_i = 4'($urandom);
      rb_addr_i = 4'($urandom);
      cycle();
    end
    idle(); cycle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule